// File: doc/BRIEF.md
# Single-Step Sequencer

This block decides when a hart that was resumed for a single step has to go back into debug mode, and why. When the hart leaves debug mode, the block samples the step enable and the step interrupt-enable bit. If the step is armed, the block watches the retire, trap-taken and trigger-fire strobes. The first of them that occurs raises a halt request together with a cause code. The request stays up until the hart reports that it has entered debug mode.

While a step is in flight, the block also shapes the hart's behaviour. It masks every interrupt, NMI included, unless the sampled interrupt-enable bit allows them. It turns an instruction that would stall the hart into a no-op. Between the end of the step and the re-entry into debug mode, it holds back any fetch fault at the new PC, so that the fault is taken after the next resume.

Top module: `step_seq`

## Requirements
- R1: After synchronous reset the outputs are idle: `step_halt_req`=0, `halt_cause`=0, `irq_mask`=0, `force_nop`=0 and `defer_fetch_fault`=0. `halt_cause` is nonzero only while `step_halt_req` is 1.
- R2: A `resume` pulse arms a step only if `step_en` is 1 in the same cycle. Later changes of `step_en` have no effect on a step that is armed, and a resume with `step_en`=0 arms nothing.
- R3: In an armed step, the first cycle with `retire`=1 raises `step_halt_req` in that same cycle with `halt_cause`=4 (single step). The request is held until `debug_enter`.
- R4: In an armed step, `trap_taken`=1 raises the request in that same cycle with `halt_cause`=4, even if no instruction retired before it. No handler instruction is waited for.
- R5: `trig_fire`=1 during an armed step gives `halt_cause`=2 (trigger). This takes precedence over `retire` or `trap_taken` in the same cycle.
- R6: `force_nop` equals `stall_insn` while a step is armed and no request is pending. In every other case it is 0.
- R7: `step_ie` is sampled at the arming resume. From the cycle after that resume until `debug_enter`, `irq_mask` is 1 if the sampled value was 0 and 0 if it was 1. When no step is in progress, `irq_mask` is 0.
- R8: `defer_fetch_fault` is 1 in exactly the cycles in which `step_halt_req` is 1.
- R9: The block raises at most one request per arming resume. Strobes that arrive while a request is pending leave `halt_cause` unchanged. A `resume` during an armed or pending step is ignored.
- R10: `debug_enter` ends the step. The request drops in the next cycle, and an armed step with no event yet is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step enable bit, sampled at resume |
| step_ie | input | 1 | Interrupt enable during a step, sampled at resume |
| resume | input | 1 | One-cycle pulse: the hart leaves debug mode |
| debug_enter | input | 1 | One-cycle pulse: the hart enters debug mode |
| retire | input | 1 | An instruction retired |
| trap_taken | input | 1 | The PC moved to a trap handler |
| trig_fire | input | 1 | A trigger with the enter-debug action fired |
| stall_insn | input | 1 | The current instruction would stall the hart |
| step_halt_req | output | 1 | Request to re-enter debug mode |
| halt_cause | output | 3 | Re-entry cause: 4 step, 2 trigger, 0 none |
| irq_mask | output | 1 | Mask all interrupts, including NMI |
| force_nop | output | 1 | Execute the stalling instruction as a no-op |
| defer_fetch_fault | output | 1 | Hold back a fetch fault at the new PC |

## Verification
The bench fires a trigger in the same cycle as a retire or a trap. A design with the priority inverted reports cause 4 there instead of 2. It changes the step and interrupt-enable bits after arming and repeats resume pulses while a step is armed. A design that reads these live would change the mask or arm a second step. It drives retire and trigger strobes while a request is pending, which catches a cause register that gets overwritten. It also asserts `debug_enter` before any event, which shows whether an aborted step leaves a stale request behind. Zero-instruction trap steps and stalling instructions both inside and outside a step complete the set.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    localparam int CAUSE_W = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = CAUSE_W'(0);
    localparam logic [CAUSE_W-1:0] CAUSE_TRIG = CAUSE_W'(2);
    localparam logic [CAUSE_W-1:0] CAUSE_STEP = CAUSE_W'(4);

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_HOLD = 2'd2
    } sq_state_t;

    typedef struct packed {
        logic                 hit;
        logic [CAUSE_W-1:0]   code;
    } step_evt_t;

    // trigger outranks a plain step completion
    function automatic logic [CAUSE_W-1:0] rank_cause(input logic trig);
        return trig ? CAUSE_TRIG : CAUSE_STEP;
    endfunction

endpackage

// File: rtl/step_evt_sel.sv
module step_evt_sel
    import step_seq_pkg::*;
(
    input  logic      armed,
    input  logic      retire,
    input  logic      trap_taken,
    input  logic      trig_fire,
    output step_evt_t evt
);
    always_comb begin
        evt.hit  = armed & (retire | trap_taken | trig_fire);
        evt.code = evt.hit ? rank_cause(trig_fire) : CAUSE_NONE;
    end
endmodule

// File: rtl/step_seq_fsm.sv
module step_seq_fsm
    import step_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               resume,
    input  logic               step_en,
    input  logic               step_ie,
    input  logic               debug_enter,
    input  step_evt_t          evt,
    output sq_state_t          state,
    output logic               ie_held,
    output logic [CAUSE_W-1:0] cause_held
);
    sq_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:  if (resume && step_en && !debug_enter) state_nx = SQ_ARMED;
            SQ_ARMED: if (debug_enter) state_nx = SQ_IDLE;
                      else if (evt.hit) state_nx = SQ_HOLD;
            SQ_HOLD:  if (debug_enter) state_nx = SQ_IDLE;
            default:  state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            ie_held    <= 1'b0;
            cause_held <= CAUSE_NONE;
        end else begin
            state <= state_nx;
            if (state == SQ_IDLE && state_nx == SQ_ARMED)
                ie_held <= step_ie;
            if (state == SQ_ARMED && state_nx == SQ_HOLD)
                cause_held <= evt.code;
            else if (state_nx == SQ_IDLE)
                cause_held <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/step_out_gate.sv
module step_out_gate
    import step_seq_pkg::*;
(
    input  sq_state_t          state,
    input  logic               ie_held,
    input  logic [CAUSE_W-1:0] cause_held,
    input  step_evt_t          evt,
    input  logic               stall_insn,
    output logic               halt_req,
    output logic [CAUSE_W-1:0] cause,
    output logic               irq_mask,
    output logic               force_nop,
    output logic               defer_fault
);
    logic in_hold;
    logic in_armed;

    always_comb begin
        in_hold     = (state == SQ_HOLD);
        in_armed    = (state == SQ_ARMED);
        halt_req    = in_hold | evt.hit;
        cause       = in_hold ? cause_held : evt.code;
        irq_mask    = (in_hold | in_armed) & ~ie_held;
        force_nop   = in_armed & stall_insn;
        defer_fault = halt_req;
    end
endmodule

// File: rtl/step_seq.sv
module step_seq
    import step_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic               step_ie,
    input  logic               resume,
    input  logic               debug_enter,
    input  logic               retire,
    input  logic               trap_taken,
    input  logic               trig_fire,
    input  logic               stall_insn,
    output logic               step_halt_req,
    output logic [CAUSE_W-1:0] halt_cause,
    output logic               irq_mask,
    output logic               force_nop,
    output logic               defer_fetch_fault
);
    sq_state_t          state;
    logic               ie_held;
    logic [CAUSE_W-1:0] cause_held;
    step_evt_t          evt;

    step_evt_sel u_sel (
        .armed      (state == SQ_ARMED),
        .retire     (retire),
        .trap_taken (trap_taken),
        .trig_fire  (trig_fire),
        .evt        (evt)
    );

    step_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .resume      (resume),
        .step_en     (step_en),
        .step_ie     (step_ie),
        .debug_enter (debug_enter),
        .evt         (evt),
        .state       (state),
        .ie_held     (ie_held),
        .cause_held  (cause_held)
    );

    step_out_gate u_gate (
        .state       (state),
        .ie_held     (ie_held),
        .cause_held  (cause_held),
        .evt         (evt),
        .stall_insn  (stall_insn),
        .halt_req    (step_halt_req),
        .cause       (halt_cause),
        .irq_mask    (irq_mask),
        .force_nop   (force_nop),
        .defer_fault (defer_fetch_fault)
    );
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk
    import step_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic               step_ie,
    input logic               resume,
    input logic               debug_enter,
    input logic               trig_fire,
    input logic               stall_insn,
    input logic               step_halt_req,
    input logic [CAUSE_W-1:0] halt_cause,
    input logic               irq_mask,
    input logic               force_nop,
    input logic               defer_fetch_fault
);
    // R1
    cause_only_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_cause != CAUSE_NONE) |-> step_halt_req);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step_halt_req && !debug_enter) |=> step_halt_req);

    // R5
    trig_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_halt_req) && trig_fire) |-> (halt_cause == CAUSE_TRIG));

    // R6
    nop_needs_stall_chk: assert property (@(posedge clk) disable iff (rst)
        force_nop |-> stall_insn);

    // R7
    mask_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_mask) |-> $past(resume && step_en && !step_ie));

    // R8
    defer_match_chk: assert property (@(posedge clk) disable iff (rst)
        defer_fetch_fault == step_halt_req);

    // R9
    cause_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (step_halt_req && !debug_enter) |=> $stable(halt_cause));

    // R10
    drop_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(step_halt_req) |-> $past(debug_enter));
endmodule

bind step_seq step_seq_chk u_step_seq_chk (
    .clk               (clk),
    .rst               (rst),
    .step_en           (step_en),
    .step_ie           (step_ie),
    .resume            (resume),
    .debug_enter       (debug_enter),
    .trig_fire         (trig_fire),
    .stall_insn        (stall_insn),
    .step_halt_req     (step_halt_req),
    .halt_cause        (halt_cause),
    .irq_mask          (irq_mask),
    .force_nop         (force_nop),
    .defer_fetch_fault (defer_fetch_fault)
);

// File: tb/step_seq_bench.sv
`timescale 1ns/1ps
module step_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 0, step_ie = 0, resume = 0, debug_enter = 0;
    logic retire = 0, trap_taken = 0, trig_fire = 0, stall_insn = 0;
    logic       step_halt_req, irq_mask, force_nop, defer_fetch_fault;
    logic [2:0] halt_cause;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit m_armed = 0;
    bit m_pend = 0;
    int m_pcause = 0;
    bit m_ie = 0;

    always #2.5 clk = ~clk;

    step_seq u_step_seq (
        .clk(clk), .rst(rst), .step_en(step_en), .step_ie(step_ie),
        .resume(resume), .debug_enter(debug_enter), .retire(retire),
        .trap_taken(trap_taken), .trig_fire(trig_fire), .stall_insn(stall_insn),
        .step_halt_req(step_halt_req), .halt_cause(halt_cause),
        .irq_mask(irq_mask), .force_nop(force_nop),
        .defer_fetch_fault(defer_fetch_fault)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // drive one cycle, compare against the model, then advance the model
    task automatic cyc(input string tag, input bit rs, input bit sen, input bit sie,
                       input bit dbg, input bit ret, input bit trp, input bit trg,
                       input bit stl);
        bit ev;
        int e_cause;
        @(negedge clk);
        resume = rs; step_en = sen; step_ie = sie; debug_enter = dbg;
        retire = ret; trap_taken = trp; trig_fire = trg; stall_insn = stl;
        #1;
        ev = m_armed && (ret || trp || trg);
        e_cause = m_pend ? m_pcause : (ev ? (trg ? 2 : 4) : 0);
        chk(tag, "step_halt_req", int'(step_halt_req), int'(m_pend || ev));
        chk(tag, "halt_cause", int'(halt_cause), e_cause);
        chk(tag, "irq_mask", int'(irq_mask), int'((m_armed || m_pend) && !m_ie));
        chk(tag, "force_nop", int'(force_nop), int'(m_armed && stl));
        chk(tag, "defer_fetch_fault", int'(defer_fetch_fault), int'(m_pend || ev));
        if (dbg) begin
            m_armed = 0; m_pend = 0;
        end else if (!m_armed && !m_pend) begin
            if (rs && sen) begin m_armed = 1; m_ie = sie; end
        end else if (ev) begin
            m_armed = 0; m_pend = 1; m_pcause = e_cause;
        end
    endtask

    task automatic quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        quiet("R1", 2);
        // R2: resume without step arms nothing
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R2", 0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1);   // stall outside a step: no nop
        // R7 mask on, R2 step bit changes ignored, R3 retire ends step
        cyc("R2", 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 1, 0, 0, 0, 0, 0);
        cyc("R2", 1, 0, 1, 0, 0, 0, 0, 0);
        cyc("R3", 0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R9", 0, 0, 0, 0, 1, 0, 1, 0);
        cyc("R8", 1, 1, 0, 0, 0, 1, 0, 1);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        quiet("R10", 2);
        // R4 trap ends step with nothing retired; ie=1 leaves interrupts open
        cyc("R4", 1, 1, 1, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R4", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R4", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        // R5 trigger with retire same cycle
        cyc("R5", 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 1, 0, 1, 0);
        cyc("R9", 0, 0, 0, 0, 1, 1, 0, 0);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        // R5 trigger with trap
        cyc("R5", 1, 1, 1, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 1, 1, 0);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        // R6 stalling instruction in a step becomes a nop
        cyc("R6", 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1);
        cyc("R6", 0, 0, 0, 0, 1, 0, 0, 1);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 1);
        // R10 abort an armed step; R9 no request after it
        cyc("R10", 1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 0, 1, 1, 1, 1);
        quiet("R1", 2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule